// File: doc/BRIEF.md
# Runaway Bus Traffic Guard

This block watches each of a set of redundant serial buses (two by default) for a remote terminal that has stopped behaving and transmits without end. Word decoding is done upstream; for each bus the guard receives a one-cycle strobe for every valid word, a tag that says whether the word carries a sync for a command or status word or is a plain data word, and a quiet-bus indication from the line monitor. A per-bus gap timer also counts clock cycles since the last word and treats a long enough silence as a quiet bus.

A bus is judged busy once a command/status word has been followed by more than 32 data words with no other sync in between. The judgement is only applied when the bus controller is told to start a message on that bus. If that bus is busy, the guard suppresses the transmission in the same cycle, latches a per-bus sticky traffic flag and raises a single-cycle interrupt. The flag for a bus stays set until the terminal is reset or that bus goes quiet. Picking the other bus after a trip is the host's job.

Each bus lane runs a three-state machine: `LN_IDLE` (no sync seen since the bus was last quiet), `LN_SYNCED` (a sync has been seen; counting data words), `LN_ACTIVE` (more than 32 data words followed the sync). Transitions: `LN_IDLE -> LN_SYNCED` on a sync word; `LN_SYNCED -> LN_SYNCED` on a data word (count +1) or a sync word (count cleared); `LN_SYNCED -> LN_ACTIVE` on the 33rd data word; `LN_ACTIVE -> LN_SYNCED` on a sync word; any state `-> LN_IDLE` when the bus is quiet, which wins over everything else in that cycle.

Top module: `runaway_traffic_guard`

## Requirements
- R1: After reset every traffic flag, every suppress output and the interrupt are 0, every lane is in LN_IDLE and every bus is treated as quiet until a word arrives.
- R2: A bus is busy only after a sync word (word_sync_i=1 with word_vld_i=1) followed by 33 data words (word_sync_i=0); after only 32 data words, or with data words and no preceding sync, a start request does not trip the guard.
- R3: A sync word restarts the data word count from zero, in any state other than a quiet cycle.
- R4: A start request on a busy, non-quiet bus sets that bus's traffic flag from the next cycle; the flag stays 1 while the bus is not quiet, and no other bus's flag changes.
- R5: tx_suppress_o[b] is 1 in the same cycle as start_req_i[b] when bus b is busy or its flag is already 1, and the bus is not quiet in that cycle; otherwise it is 0.
- R6: irq_o is a one-cycle pulse, high in the first cycle a traffic flag reads 1, and 0 in the next cycle unless another flag rises then.
- R7: bus_quiet_i[b]=1 clears flag b and returns lane b to LN_IDLE at the next edge.
- R8: IDLE_CYCLES or more cycles with no word on bus b count as quiet on bus b, with the same effect as R7, until the next word arrives.
- R9: The lanes are independent: words, quiet and requests on one bus never change the other bus's flag, suppress output or busy state.
- R10: If quiet and a start request arrive on a busy bus in the same cycle, quiet wins: no suppress, no flag, no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Terminal reset, active low |
| word_vld_i | input | NBUS | One-cycle strobe per decoded word, one bit per bus |
| word_sync_i | input | NBUS | 1 = command/status word, 0 = data word; valid with word_vld_i |
| bus_quiet_i | input | NBUS | Quiet-bus indication from the line monitor |
| start_req_i | input | NBUS | Controller told to start a message on bus b |
| traffic_flag_o | output | NBUS | Sticky continuous-traffic flag per bus |
| tx_suppress_o | output | NBUS | Suppress the requested transmission on bus b |
| irq_o | output | 1 | One-cycle interrupt on a flag rising |

## Verification
Directed runs put exactly 32 and then 33 data words after a sync, long data runs with no sync at all, and a sync landing in the middle of a run, which separates an off-by-one in the threshold from a counter that ignores resynchronisation. Silences just shorter and longer than the idle time, and quiet arriving with a request, tell the quiet paths apart from the flag-set path. Traffic and requests on both buses at once show whether state leaks between lanes. A long seeded random stream with bursty words, rare syncs and occasional silences is then compared cycle by cycle against a bench model of the requirements.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    typedef enum logic [1:0] {
        LN_IDLE   = 2'd0,
        LN_SYNCED = 2'd1,
        LN_ACTIVE = 2'd2
    } lane_state_t;
endpackage

// File: rtl/rtg_gap_timer.sv
module rtg_gap_timer #(
    parameter int IDLE_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    output logic gap_idle_o
);
    localparam int GW = $clog2(IDLE_CYCLES + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(IDLE_CYCLES);

    logic [GW-1:0] gap_q;

    // Saturating count of cycles since the last word; starts saturated.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            gap_q <= GAP_MAX;
        else if (word_vld)
            gap_q <= '0;
        else if (gap_q != GAP_MAX)
            gap_q <= gap_q + 1'b1;
    end

    assign gap_idle_o = (gap_q == GAP_MAX);

    // R8: a word always pulls the timer out of the idle condition
    a_r8_word_restarts_gap: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !gap_idle_o);
endmodule

// File: rtl/rtg_lane.sv
module rtg_lane
    import rtg_pkg::*;
#(
    parameter int RUN_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic word_sync,
    input  logic bus_quiet,
    input  logic gap_idle,
    input  logic start_req,
    output logic flag_o,
    output logic suppress_o,
    output logic trip_o
);
    localparam int CW = $clog2(RUN_LIMIT + 2);
    localparam logic [CW-1:0] LAST_COUNT = CW'(RUN_LIMIT);

    lane_state_t state_q, state_d;
    logic [CW-1:0] run_q, run_d;
    logic flag_q, flag_d;
    logic quiet_now;
    logic busy;

    assign quiet_now = bus_quiet | (gap_idle & ~word_vld);
    assign busy      = (state_q == LN_ACTIVE);

    // Next-state logic for the run detector.
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        unique case (state_q)
            LN_IDLE: begin
                if (word_vld && word_sync) begin
                    state_d = LN_SYNCED;
                    run_d   = '0;
                end
            end
            LN_SYNCED: begin
                if (word_vld && word_sync) begin
                    run_d = '0;
                end else if (word_vld) begin
                    run_d = run_q + 1'b1;
                    if (run_q == LAST_COUNT)
                        state_d = LN_ACTIVE;
                end
            end
            LN_ACTIVE: begin
                if (word_vld && word_sync) begin
                    state_d = LN_SYNCED;
                    run_d   = '0;
                end
            end
            default: begin
                state_d = LN_IDLE;
                run_d   = '0;
            end
        endcase
        if (quiet_now) begin
            state_d = LN_IDLE;
            run_d   = '0;
        end
    end

    // Output logic: trip, suppress and next flag.
    always_comb begin
        trip_o     = start_req & busy & ~quiet_now;
        suppress_o = start_req & (busy | flag_q) & ~quiet_now;
        if (quiet_now)
            flag_d = 1'b0;
        else if (trip_o)
            flag_d = 1'b1;
        else
            flag_d = flag_q;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LN_IDLE;
            run_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
            flag_q  <= flag_d;
        end
    end

    assign flag_o = flag_q;

    // R4: a request on a busy, non-quiet bus latches the flag
    a_r4_trip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && state_q == LN_ACTIVE && !bus_quiet && !gap_idle) |=> flag_q);
    // R7: external quiet clears the flag and the lane
    a_r7_quiet_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_quiet |=> (!flag_q && state_q == LN_IDLE));
    // R5: a flag can only rise in a cycle whose request was suppressed
    a_r5_rise_was_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(suppress_o));
    // R2: busy is reached only from the counting state after the last data word
    a_r2_active_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == LN_ACTIVE) |-> ($past(state_q) == LN_SYNCED && $past(run_q) == LAST_COUNT));
    // R3: a sync word leaves the lane counting from zero
    a_r3_sync_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word_sync && !bus_quiet) |=> (state_q == LN_SYNCED && run_q == '0));
    // R10: quiet blocks suppression
    a_r10_quiet_no_suppress: assert property (@(posedge clk) disable iff (!rst_n)
        bus_quiet |-> !suppress_o);
endmodule

// File: rtl/runaway_traffic_guard.sv
module runaway_traffic_guard #(
    parameter int NBUS        = 2,
    parameter int RUN_LIMIT   = 32,
    parameter int IDLE_CYCLES = 400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUS-1:0] word_vld_i,
    input  logic [NBUS-1:0] word_sync_i,
    input  logic [NBUS-1:0] bus_quiet_i,
    input  logic [NBUS-1:0] start_req_i,
    output logic [NBUS-1:0] traffic_flag_o,
    output logic [NBUS-1:0] tx_suppress_o,
    output logic            irq_o
);
    logic [NBUS-1:0] gap_idle;
    logic [NBUS-1:0] trip;
    logic            irq_q;

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        rtg_gap_timer #(
            .IDLE_CYCLES(IDLE_CYCLES)
        ) u_gap (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_vld  (word_vld_i[b]),
            .gap_idle_o(gap_idle[b])
        );

        rtg_lane #(
            .RUN_LIMIT(RUN_LIMIT)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_vld  (word_vld_i[b]),
            .word_sync (word_sync_i[b]),
            .bus_quiet (bus_quiet_i[b]),
            .gap_idle  (gap_idle[b]),
            .start_req (start_req_i[b]),
            .flag_o    (traffic_flag_o[b]),
            .suppress_o(tx_suppress_o[b]),
            .trip_o    (trip[b])
        );
    end

    // Interrupt on the cycle a flag first reads 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= |(trip & ~traffic_flag_o);
    end

    assign irq_o = irq_q;

    // R6: the interrupt only marks a rising flag
    a_r6_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|(traffic_flag_o & ~$past(traffic_flag_o))));
    // R6: a rising flag always raises the interrupt
    a_r6_rise_gives_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (|(traffic_flag_o & ~$past(traffic_flag_o))) |-> irq_o);
endmodule

// File: tb/sim_runaway_traffic_guard.sv
module sim_runaway_traffic_guard;
    localparam int NB   = 2;
    localparam int IDLE = 40;
    localparam int RUNL = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NB-1:0] vld = '0, syn = '0, qui = '0, req = '0;
    logic [NB-1:0] flag, sup;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the requirements
    int m_gap  [NB];
    int m_cnt  [NB];
    int m_st   [NB]; // 0 idle, 1 counting, 2 busy
    bit m_flag [NB];
    bit m_irq;

    always #5 clk = ~clk;

    runaway_traffic_guard #(
        .NBUS(NB), .RUN_LIMIT(RUNL), .IDLE_CYCLES(IDLE)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .word_vld_i(vld), .word_sync_i(syn),
        .bus_quiet_i(qui), .start_req_i(req),
        .traffic_flag_o(flag), .tx_suppress_o(sup), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit quiet_now(input int b, input logic [NB-1:0] v, input logic [NB-1:0] q);
        return q[b] || (m_gap[b] >= IDLE && !v[b]);
    endfunction

    function automatic logic [NB-1:0] exp_sup(input logic [NB-1:0] v, input logic [NB-1:0] q,
                                              input logic [NB-1:0] r);
        logic [NB-1:0] e = '0;
        for (int b = 0; b < NB; b++)
            e[b] = r[b] && (m_st[b] == 2 || m_flag[b]) && !quiet_now(b, v, q);
        return e;
    endfunction

    function automatic logic [NB-1:0] flag_vec();
        logic [NB-1:0] f;
        for (int b = 0; b < NB; b++) f[b] = m_flag[b];
        return f;
    endfunction

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_gap[b] = IDLE; m_cnt[b] = 0; m_st[b] = 0; m_flag[b] = 0;
        end
        m_irq = 0;
    endtask

    task automatic model_update(input logic [NB-1:0] v, input logic [NB-1:0] s,
                                input logic [NB-1:0] q, input logic [NB-1:0] r);
        bit irq_n = 0;
        for (int b = 0; b < NB; b++) begin
            bit qn = quiet_now(b, v, q);
            bit trip = r[b] && m_st[b] == 2 && !qn;
            if (trip && !m_flag[b]) irq_n = 1;
            if (qn) m_flag[b] = 0; else if (trip) m_flag[b] = 1;
            if (qn) begin
                m_st[b] = 0; m_cnt[b] = 0;
            end else if (v[b] && s[b]) begin
                m_st[b] = 1; m_cnt[b] = 0;
            end else if (v[b] && m_st[b] == 1) begin
                m_cnt[b]++;
                if (m_cnt[b] > RUNL) m_st[b] = 2;
            end
            if (v[b]) m_gap[b] = 0; else if (m_gap[b] < IDLE) m_gap[b]++;
        end
        m_irq = irq_n;
    endtask

    // one cycle: drive, check suppress, clock, check flag and irq
    task automatic step(input logic [NB-1:0] v, input logic [NB-1:0] s,
                        input logic [NB-1:0] q, input logic [NB-1:0] r, input string tag);
        @(negedge clk);
        vld = v; syn = s; qui = q; req = r;
        #1;
        check({tag, " R5 suppress"}, 32'(sup), 32'(exp_sup(v, q, r)));
        @(posedge clk);
        model_update(v, s, q, r);
        #1;
        check({tag, " R4 flag"}, 32'(flag), 32'(flag_vec()));
        check({tag, " R6 irq"}, 32'(irq), 32'(m_irq));
    endtask

    task automatic idle_step(input string tag);
        step('0, '0, '0, '0, tag);
    endtask

    // sync then n data words on the buses in mask
    task automatic burst(input logic [NB-1:0] m, input int n, input string tag);
        step(m, m, '0, '0, tag);
        for (int i = 0; i < n; i++) step(m, '0, '0, '0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 flag", 32'(flag), 0);
        check("R1 suppress", 32'(sup), 0);
        check("R1 irq", 32'(irq), 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: bus quiet after reset, a request is never suppressed
        step('0, '0, '0, 2'b11, "R1");

        // R2: 32 data words are not enough
        burst(2'b01, 32, "R2");
        step(2'b01, '0, '0, 2'b01, "R2");  // 33rd data word with request: not yet busy
        check("R2 no trip at 32", 32'(flag), 0);
        step(2'b01, '0, '0, 2'b01, "R4");  // now busy: suppress and trip
        check("R4 flag set", 32'(flag), 1);
        check("R6 irq high", 32'(irq), 1);
        step(2'b01, '0, '0, '0, "R6");
        check("R6 irq one cycle", 32'(irq), 0);
        check("R4 sticky", 32'(flag), 1);
        step(2'b01, 2'b01, '0, 2'b01, "R5"); // flag holds suppress even after resync

        // R7: quiet clears
        step(2'b01, '0, 2'b01, '0, "R7");
        check("R7 flag clear", 32'(flag), 0);

        // R2: data words with no sync never make the bus busy
        for (int i = 0; i < 40; i++) step(2'b01, '0, '0, '0, "R2");
        step(2'b01, '0, '0, 2'b01, "R2");
        check("R2 no sync no trip", 32'(flag), 0);

        // R3: a sync in the middle restarts the count
        burst(2'b01, 20, "R3");
        burst(2'b01, 32, "R3");
        step('0, '0, '0, 2'b01, "R3");
        check("R3 restart", 32'(flag), 0);
        step(2'b01, '0, '0, '0, "R3");
        step('0, '0, '0, 2'b01, "R3");
        check("R3 trip after restart", 32'(flag), 1);

        // R8: gap shorter than idle keeps the flag, reaching idle clears it
        for (int i = 0; i < IDLE - 1; i++) idle_step("R8");
        check("R8 short gap", 32'(flag), 1);
        idle_step("R8");
        idle_step("R8");
        check("R8 gap clears", 32'(flag), 0);

        // R9: bus 1 trips, bus 0 left alone
        burst(2'b11, 33, "R9");
        step('0, '0, '0, 2'b10, "R9");
        check("R9 only bus1", 32'(flag), 2);
        step('0, '0, 2'b10, '0, "R9");
        step('0, '0, '0, 2'b01, "R9");
        check("R9 bus0 then", 32'(flag), 1);

        // R10: quiet with request on a busy bus
        step('0, '0, 2'b01, '0, "R10");
        burst(2'b10, 33, "R10");
        step('0, '0, 2'b10, 2'b10, "R10");
        check("R10 no flag", 32'(flag), 0);

        // seeded random traffic
        begin
            int unsigned seed = 32'h1F2E3D4C;
            void'($urandom(seed));
            for (int i = 0; i < 6000; i++) begin
                logic [NB-1:0] v, s, q, r;
                if ((i % 700) > 650) begin
                    v = '0; s = '0;
                end else begin
                    for (int b = 0; b < NB; b++) begin
                        v[b] = ($urandom % 100) < 85;
                        s[b] = ($urandom % 100) < 2;
                    end
                end
                for (int b = 0; b < NB; b++) begin
                    q[b] = ($urandom % 1000) < 3;
                    r[b] = ($urandom % 100) < 8;
                end
                step(v, s, q, r, "rand R2 R3 R7 R8 R9 R10");
            end
        end
        finish_run();
    end
endmodule